// File: doc/BRIEF.md
# Flash controller interrupt register bank

This block gathers the event and level conditions reported by the FIFO logic of a serial flash controller and turns them into a single interrupt request. It sits behind a plain 32-bit register port (address, write strobe, write data, combinational read data) and presents four registers: a status view, a write-only enable port, a write-only disable port and a read-only mask view.

The status view mixes two kinds of bit. The poll-timeout condition is latched: a one-cycle pulse on its input sets the bit, and it stays set until software writes a one to it. The nine FIFO condition bits are not stored at all; they show the live state of the transmit, receive and command FIFOs. Masking is done through set/clear ports rather than a read/write register, so a driver can enable or disable one source without a read-modify-write. The interrupt output is a flop fed by the OR of every status bit whose mask bit is clear.

Register offsets (byte addresses, full address compared): 0x0 status, 0x4 enable, 0x8 disable, 0xC mask. Any other address reads zero and ignores writes.

Top module: `flash_irq_regs`

## Requirements
- R1: After reset the mask view reads 0x0000_0FBE (every implemented source masked), the latched poll-timeout bit is clear and the interrupt output is low.
- R2: Reading offset 0x0 returns the live FIFO conditions in the same cycle at these positions: bit 2 TX not full, bit 3 TX full, bit 4 RX not empty, bit 5 RX full, bit 7 command FIFO empty, bit 8 TX empty, bit 9 command FIFO not full, bit 10 command FIFO full, bit 11 RX empty.
- R3: A one-cycle pulse on the poll-timeout input sets status bit 1 on the next clock edge, and the bit stays set while no clearing write reaches it.
- R4: A write to offset 0x0 clears status bit 1 where the data has a one; zero data bits and the live FIFO bits are not changed by such a write.
- R5: When a poll-timeout pulse and a clearing write to bit 1 fall in the same cycle, bit 1 is set after the edge.
- R6: A write to offset 0x4 clears each mask bit whose data bit is one and leaves the other mask bits unchanged.
- R7: A write to offset 0x8 sets each implemented mask bit whose data bit is one; writing 0xFBE masks every source.
- R8: Bits 0, 6 and 12 to 31 read as zero in the status and mask views whatever is written to any register.
- R9: Offsets 0x4 and 0x8 read as zero, and writes to offset 0xC or to unmapped addresses change nothing.
- R10: The interrupt output equals, one clock later, the OR over all bits of status AND NOT mask.
- R11: Writing back to offset 0x0 the value just read from it clears every latched bit that was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| ev_poll_to | input | 1 | Poll-timeout event pulse |
| lv_tx_nfull | input | 1 | TX FIFO not full |
| lv_tx_full | input | 1 | TX FIFO full |
| lv_rx_nempty | input | 1 | RX FIFO not empty |
| lv_rx_full | input | 1 | RX FIFO full |
| lv_cmd_empty | input | 1 | Command FIFO empty |
| lv_tx_empty | input | 1 | TX FIFO empty |
| lv_cmd_nfull | input | 1 | Command FIFO not full |
| lv_cmd_full | input | 1 | Command FIFO full |
| lv_rx_empty | input | 1 | RX FIFO empty |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is the collision of a poll-timeout pulse with a clearing write to the same bit, since both must land in one exact cycle; the bench drives the pulse and the status write from the same step so they share a clock edge, then reads the bit back in the next step. The write-back clear is exercised by reading the status view while live FIFO bits are also high and writing that whole value back, which shows the live bits are unaffected while the latched one drops. A long stretch of random writes, addresses and FIFO levels is then compared against a behavioural model on every clock.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

   // Byte offsets of the register views
   localparam int OFS_STAT = 'h0;
   localparam int OFS_ENA  = 'h4;
   localparam int OFS_DIS  = 'h8;
   localparam int OFS_MASK = 'hC;

   // Status bit positions (decoded by software, so fixed)
   localparam int BIT_POLL_TO   = 1;
   localparam int BIT_TX_NFULL  = 2;
   localparam int BIT_TX_FULL   = 3;
   localparam int BIT_RX_NEMPTY = 4;
   localparam int BIT_RX_FULL   = 5;
   localparam int BIT_CMD_EMPTY = 7;
   localparam int BIT_TX_EMPTY  = 8;
   localparam int BIT_CMD_NFULL = 9;
   localparam int BIT_CMD_FULL  = 10;
   localparam int BIT_RX_EMPTY  = 11;
   localparam int TOP_BIT       = 11;

   localparam logic [31:0] DEF_IMPL   = 32'h0000_0FBE;
   localparam logic [31:0] DEF_STICKY = 32'h0000_0002;

   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_STAT = 2'd1,
      RSEL_MASK = 2'd2
   } rsel_e;

endpackage

// File: rtl/flash_irq_decode.sv
module flash_irq_decode
   import flash_irq_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] clr_v,
   output logic [DATA_W-1:0] ena_v,
   output logic [DATA_W-1:0] dis_v,
   output rsel_e             rsel
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
   localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

   logic hit_stat, hit_ena, hit_dis, hit_mask;

   always_comb begin
      hit_stat = (addr == A_STAT);
      hit_ena  = (addr == A_ENA);
      hit_dis  = (addr == A_DIS);
      hit_mask = (addr == A_MASK);
      clr_v    = (wr && hit_stat) ? wdata : '0;
      ena_v    = (wr && hit_ena)  ? wdata : '0;
      dis_v    = (wr && hit_dis)  ? wdata : '0;
      if (hit_stat)      rsel = RSEL_STAT;
      else if (hit_mask) rsel = RSEL_MASK;
      else               rsel = RSEL_NONE;
   end

endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status #(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] IMPL_MASK  = 32'h0000_0FBE,
   parameter logic [31:0] STICKY_MSK = 32'h0000_0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_v,
   input  logic [DATA_W-1:0] clr_v,
   output logic [DATA_W-1:0] stat_v
);

   localparam logic [DATA_W-1:0] STK  = DATA_W'(STICKY_MSK & IMPL_MASK);
   localparam logic [DATA_W-1:0] LIVE = DATA_W'(IMPL_MASK & ~STICKY_MSK);

   logic [DATA_W-1:0] sticky_q;

   // Set term is ORed in after the clear, so a coincident event wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= ((sticky_q & ~clr_v) | src_v) & STK;
   end

   assign stat_v = (sticky_q & STK) | (src_v & LIVE);

endmodule

// File: rtl/flash_irq_mask.sv
module flash_irq_mask #(
   parameter int          DATA_W    = 32,
   parameter logic [31:0] IMPL_MASK = 32'h0000_0FBE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ena_v,
   input  logic [DATA_W-1:0] dis_v,
   output logic [DATA_W-1:0] mask_v
);

   localparam logic [DATA_W-1:0] IMP = DATA_W'(IMPL_MASK);

   logic [DATA_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= IMP;
      else        mask_q <= ((mask_q & ~ena_v) | dis_v) & IMP;
   end

   assign mask_v = mask_q;

endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
   import flash_irq_pkg::*;
#(
   parameter int          ADDR_W     = 4,
   parameter int          DATA_W     = 32,
   parameter logic [31:0] IMPL_MASK  = DEF_IMPL,
   parameter logic [31:0] STICKY_MSK = DEF_STICKY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_poll_to,
   input  logic              lv_tx_nfull,
   input  logic              lv_tx_full,
   input  logic              lv_rx_nempty,
   input  logic              lv_rx_full,
   input  logic              lv_cmd_empty,
   input  logic              lv_tx_empty,
   input  logic              lv_cmd_nfull,
   input  logic              lv_cmd_full,
   input  logic              lv_rx_empty,
   output logic              irq
);

   // Elaboration-time parameter checks
   generate
      if (DATA_W <= TOP_BIT) begin : g_bad_width
         $error("DATA_W must hold every status bit position");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must reach the highest register offset");
      end
      if ((STICKY_MSK & ~IMPL_MASK) != 32'h0) begin : g_bad_sticky
         $error("STICKY_MSK may only name implemented bits");
      end
   endgenerate

   logic [DATA_W-1:0] src_v;
   logic [DATA_W-1:0] clr_v, ena_v, dis_v;
   logic [DATA_W-1:0] stat_v, mask_v;
   rsel_e             rsel;
   logic              irq_q;

   always_comb begin
      src_v                = '0;
      src_v[BIT_POLL_TO]   = ev_poll_to;
      src_v[BIT_TX_NFULL]  = lv_tx_nfull;
      src_v[BIT_TX_FULL]   = lv_tx_full;
      src_v[BIT_RX_NEMPTY] = lv_rx_nempty;
      src_v[BIT_RX_FULL]   = lv_rx_full;
      src_v[BIT_CMD_EMPTY] = lv_cmd_empty;
      src_v[BIT_TX_EMPTY]  = lv_tx_empty;
      src_v[BIT_CMD_NFULL] = lv_cmd_nfull;
      src_v[BIT_CMD_FULL]  = lv_cmd_full;
      src_v[BIT_RX_EMPTY]  = lv_rx_empty;
   end

   flash_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .addr  (reg_addr),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .clr_v (clr_v),
      .ena_v (ena_v),
      .dis_v (dis_v),
      .rsel  (rsel)
   );

   flash_irq_status #(
      .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .STICKY_MSK(STICKY_MSK)
   ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_v  (src_v),
      .clr_v  (clr_v),
      .stat_v (stat_v)
   );

   flash_irq_mask #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .ena_v  (ena_v),
      .dis_v  (dis_v),
      .mask_v (mask_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_v & ~mask_v);
   end

   always_comb begin
      unique case (rsel)
         RSEL_STAT: reg_rdata = stat_v;
         RSEL_MASK: reg_rdata = mask_v;
         default:   reg_rdata = '0;
      endcase
   end

   assign irq = irq_q;

endmodule

// File: rtl/flash_irq_regs_chk.sv
module flash_irq_regs_chk #(
   parameter int          DATA_W     = 32,
   parameter logic [31:0] IMPL_MASK  = 32'h0000_0FBE,
   parameter logic [31:0] STICKY_MSK = 32'h0000_0002
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] src_v,
   input logic [DATA_W-1:0] clr_v,
   input logic [DATA_W-1:0] ena_v,
   input logic [DATA_W-1:0] dis_v,
   input logic [DATA_W-1:0] stat_v,
   input logic [DATA_W-1:0] mask_v,
   input logic              irq
);

   localparam logic [DATA_W-1:0] STK = DATA_W'(STICKY_MSK & IMPL_MASK);
   localparam logic [DATA_W-1:0] IMP = DATA_W'(IMPL_MASK);

   // R10
   irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(stat_v & ~mask_v))));

   // R5
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_v & STK)) |=> ((stat_v & $past(src_v & STK)) == $past(src_v & STK)));

   // R3
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_v & $past(stat_v & STK & ~clr_v)) == $past(stat_v & STK & ~clr_v)));

   // R4
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_v & STK & ~src_v)) |=> ((stat_v & $past(clr_v & STK & ~src_v)) == '0));

   // R6
   enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ena_v) |=> ((mask_v & $past(ena_v & ~dis_v)) == '0));

   // R7
   disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(dis_v & IMP)) |=> ((mask_v & $past(dis_v & IMP)) == $past(dis_v & IMP)));

endmodule

bind flash_irq_regs flash_irq_regs_chk #(
   .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .STICKY_MSK(STICKY_MSK)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .src_v  (src_v),
   .clr_v  (clr_v),
   .ena_v  (ena_v),
   .dis_v  (dis_v),
   .stat_v (stat_v),
   .mask_v (mask_v),
   .irq    (irq)
);

// File: tb/sim_flash_irq_regs.sv
`timescale 1ns/1ps
module sim_flash_irq_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [11:0] src = '0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // behavioural model state
   logic [31:0] m_sticky;
   logic [31:0] m_mask;
   logic        m_irq;

   always #2.5 clk = ~clk;

   flash_irq_regs u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr     (reg_addr),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .ev_poll_to   (src[1]),
      .lv_tx_nfull  (src[2]),
      .lv_tx_full   (src[3]),
      .lv_rx_nempty (src[4]),
      .lv_rx_full   (src[5]),
      .lv_cmd_empty (src[7]),
      .lv_tx_empty  (src[8]),
      .lv_cmd_nfull (src[9]),
      .lv_cmd_full  (src[10]),
      .lv_rx_empty  (src[11]),
      .irq          (irq)
   );

   function automatic logic [31:0] stat_now();
      return (m_sticky & 32'h2) | ({20'h0, src} & 32'hFBC);
   endfunction

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'h0:    return stat_now();
         4'hC:    return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // one clock of stimulus, checked before and after the edge
   task automatic step(input string req, input logic [3:0] a, input logic w,
                       input logic [31:0] d, input logic [11:0] s);
      logic        nirq;
      logic [31:0] nst, nmk;
      reg_addr  = a;
      reg_wr    = w;
      reg_wdata = d;
      src       = s;
      #1;
      cmp(req, "rdata", reg_rdata, exp_read(a));
      nirq = |(stat_now() & ~m_mask);
      nst  = m_sticky;
      if (w && a == 4'h0) nst = nst & ~d;
      nst  = (nst | {20'h0, s}) & 32'h2;
      nmk  = m_mask;
      if (w && a == 4'h4) nmk = nmk & ~d;
      if (w && a == 4'h8) nmk = nmk | (d & 32'hFBE);
      @(posedge clk);
      #1;
      m_sticky = nst;
      m_mask   = nmk;
      m_irq    = nirq;
      cmp(req, "irq", {31'h0, irq}, {31'h0, m_irq});
   endtask

   function automatic string finish_line();
      return $sformatf("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endfunction

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%s", finish_line());
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      m_sticky = '0;
      m_mask   = 32'hFBE;
      m_irq    = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      step("R1", 4'hC, 0, 0, 12'h000);
      step("R1", 4'h0, 0, 0, 12'h000);

      // R2 live conditions, several patterns
      step("R2", 4'h0, 0, 0, 12'h014);
      step("R2", 4'h0, 0, 0, 12'h9A0);
      step("R2", 4'h0, 0, 0, 12'hFBC);
      step("R2", 4'h0, 0, 0, 12'hFFD);

      // R3 poll pulse latches and holds
      step("R3", 4'h0, 0, 0, 12'h002);
      step("R3", 4'h0, 0, 0, 12'h000);
      step("R3", 4'h0, 0, 0, 12'h100);

      // R4 zero write and live-bit write have no effect, one clears
      step("R4", 4'h0, 1, 32'h0, 12'h100);
      step("R4", 4'h0, 1, 32'hFBC, 12'h100);
      step("R4", 4'h0, 0, 0, 12'h100);
      step("R4", 4'h0, 1, 32'h2, 12'h100);
      step("R4", 4'h0, 0, 0, 12'h100);

      // R5 set event beats a coincident clear
      step("R5", 4'h0, 1, 32'h2, 12'h002);
      step("R5", 4'h0, 0, 0, 12'h000);

      // R6 / R10 unmask poll timeout, irq one cycle later
      step("R6", 4'h4, 1, 32'h2, 12'h000);
      step("R10", 4'hC, 0, 0, 12'h000);
      step("R10", 4'h0, 1, 32'h2, 12'h000);
      step("R10", 4'h0, 0, 0, 12'h000);

      // R8 unmask everything, unimplemented stay zero; live bit fires irq
      step("R8", 4'h4, 1, 32'hFFFF_FFFF, 12'h000);
      step("R8", 4'hC, 0, 0, 12'h010);
      step("R10", 4'h0, 0, 0, 12'h000);

      // R7 disable all
      step("R7", 4'h8, 1, 32'hFBE, 12'hFBC);
      step("R7", 4'hC, 0, 0, 12'hFBC);
      step("R8", 4'h8, 1, 32'hFFFF_FFFF, 12'hFBC);
      step("R8", 4'hC, 0, 0, 12'h000);

      // R9 mask view is read-only, set/clear ports read zero, unmapped ignored
      step("R9", 4'hC, 1, 32'h0, 12'h000);
      step("R9", 4'hC, 0, 0, 12'h000);
      step("R9", 4'h4, 0, 0, 12'h000);
      step("R9", 4'h8, 0, 0, 12'h000);
      step("R9", 4'h6, 1, 32'hFFFF_FFFF, 12'h002);
      step("R9", 4'h0, 0, 0, 12'h000);

      // R11 write back what was read
      step("R11", 4'h0, 0, 0, 12'h3A4);
      rv = stat_now();
      step("R11", 4'h0, 1, rv, 12'h3A4);
      step("R11", 4'h0, 0, 0, 12'h3A4);

      // random traffic compared every clock
      for (int i = 0; i < 3000; i++) begin
         logic [3:0]  a;
         logic [31:0] d;
         logic [11:0] s;
         a = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) != 0) a = {a[3:2], 2'b00};
         d = $urandom();
         s = 12'($urandom());
         if ($urandom_range(0, 3) != 0) s[1] = 1'b0;
         step("R10", a, 1'($urandom_range(0, 1)), d, s);
      end

      done = 1;
      $display("%s", finish_line());
      $finish;
   end

endmodule